// File: doc/BRIEF.md
# Multiply/Divide Issue and Latency Controller

This block paces a single shared integer multiply/divide unit inside an in-order pipeline. It produces no arithmetic. It decides whether a start request from the pipeline may issue now. It picks how long the issued operation takes. It raises a one-cycle completion pulse carrying the instruction's tag when that time has passed. It answers end polls from the pipeline, and the pipeline retries each poll until the operation has finished.

The pipeline sends commands on one request port. A start command carries an operation class, the divisor operand and a tag. A granted start lets the instruction move on at once, while an internal countdown runs. An end command for the same tag succeeds only once the countdown has expired. The block holds one instruction at a time.

A divide falls into one of four magnitude classes, found from the most significant nonzero byte of its divisor. Each class has its own latency. The minimum spacing before the next new issue depends on what the previous issued operation was. Multiply, and each of the four divide classes, has its own latency and its own spacing, fixed by parameters.

Top module: `mdu_issue_ctrl`

## Requirements
- R1: After reset no instruction is held and no previous operation is recorded. `done_valid` is low, an end poll does not complete, and a start in the first cycle after reset is granted. Reset given during a running countdown cancels it, so its completion pulse never appears.
- R2: A divide's divisor is read as an unsigned 32-bit value. Values up to 0xFF are class 8, up to 0xFFFF class 16, up to 0xFFFFFF class 24, and larger values class 32. The class selects the divide's latency and its spacing.
- R3: `done_valid` is high for exactly one cycle, L cycles after the cycle in which a new instruction's start was granted. `done_tag` then equals that instruction's tag. L is the multiply latency when `req_op` is 0, whatever the divisor, and the class latency when `req_op` is 1.
- R4: A start for a new instruction is denied while fewer cycles have passed since the previous new issue than the spacing of that previous operation. That spacing is the multiply spacing after a multiply and the class spacing after a divide. The start is granted in the first cycle that reaches the spacing.
- R5: While an instruction is held, whether its countdown is running or it is waiting for its end poll, a start (`req_cmd` = 1) carrying any other tag is denied.
- R6: A start carrying the held tag is granted without any spacing check. It does not restart the countdown and causes no extra completion pulse.
- R7: An end poll (`req_cmd` = 2) carrying the held tag completes once the countdown has expired, including in the cycle of the completion pulse itself, and the instruction is then released. Before expiry the poll does not complete and may be repeated.
- R8: An end poll carrying a tag that is not held does not complete, and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_cmd | input | 2 | 0 idle, 1 start, 2 end poll, 3 ignored |
| req_op | input | 1 | Operation class for a start: 0 multiply, 1 divide |
| req_divisor | input | 32 | Divisor operand (second source) of a divide |
| req_tag | input | TAG_W | Tag identifying the requesting instruction |
| start_grant | output | 1 | Start request granted this cycle (combinational) |
| end_complete | output | 1 | End poll completed this cycle (combinational) |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | TAG_W | Tag of the completing instruction |

## Verification
Countdown expiry and the end poll can land in the same cycle. The pipeline polls in exactly the cycle where `done_valid` rises, and that poll must complete, because an implementation that looks only at a registered "finished" flag would complete one cycle late. Every latency measurement ends with this coincident poll, for every divisor class and for multiply. A second overlap is a repeated start for the held tag arriving while the countdown runs. It is judged by checking that the later pulse comes at the original time, and only once.

// File: rtl/mdu_issue_pkg.sv
package mdu_issue_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_START = 2'd1,
        CMD_END   = 2'd2,
        CMD_RSVD  = 2'd3
    } mdu_cmd_e;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } mdu_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_24 = 2'd2,
        SZ_32 = 2'd3
    } div_size_e;

    // timing kind: 0 multiply, 1..4 divide classes 8..32
    localparam int NUM_KINDS = 5;
    localparam int KIND_W    = 3;
    localparam int TIME_W    = 8;
    typedef logic [KIND_W-1:0] kind_t;

    typedef struct packed {
        logic  valid;
        kind_t kind;
    } last_op_t;

    function automatic kind_t kind_of(mdu_op_e op, div_size_e sz);
        kind_t k;
        if (op == OP_MUL) k = kind_t'(0);
        else              k = kind_t'(1) + kind_t'(sz);
        return k;
    endfunction

endpackage

// File: rtl/mdu_size_class.sv
module mdu_size_class
    import mdu_issue_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] divisor,
    output div_size_e         size
);
    localparam int NBYTES = DATA_W / 8;

    logic [NBYTES-1:0] byte_nz;

    genvar gb;
    generate
        for (gb = 0; gb < NBYTES; gb++) begin : g_byte
            assign byte_nz[gb] = |divisor[gb*8 +: 8];
        end
    endgenerate

    // highest nonzero byte decides the class; bytes 3 and up map to 32
    always_comb begin
        size = SZ_8;
        for (int i = 1; i < NBYTES; i++) begin
            if (byte_nz[i]) begin
                if (i >= 3) size = SZ_32;
                else        size = div_size_e'(2'(i));
            end
        end
    end

endmodule

// File: rtl/mdu_kind_table.sv
module mdu_kind_table
    import mdu_issue_pkg::*;
#(
    parameter int                      NK  = NUM_KINDS,
    parameter logic [NK*TIME_W-1:0]    TAB = '0
) (
    input  kind_t             kind,
    output logic [TIME_W-1:0] value
);
    logic [NK-1:0][TIME_W-1:0] pick;

    genvar gk;
    generate
        for (gk = 0; gk < NK; gk++) begin : g_entry
            assign pick[gk] = (kind == kind_t'(gk)) ? TAB[gk*TIME_W +: TIME_W]
                                                    : '0;
        end
    endgenerate

    always_comb begin
        value = '0;
        for (int i = 0; i < NK; i++) value = value | pick[i];
    end

endmodule

// File: rtl/mdu_spacing_gate.sv
module mdu_spacing_gate
    import mdu_issue_pkg::*;
#(
    parameter int                          CYC_W   = 32,
    parameter logic [NUM_KINDS*TIME_W-1:0] RPT_TAB = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  issue_fire,
    input  kind_t issue_kind,
    output logic  spacing_ok
);
    logic [CYC_W-1:0]  cyc_q;
    logic [CYC_W-1:0]  last_cyc_q;
    last_op_t          last_q;
    logic [TIME_W-1:0] rate;
    logic [CYC_W-1:0]  elapsed;

    mdu_kind_table #(
        .NK  (NUM_KINDS),
        .TAB (RPT_TAB)
    ) u_rpt (
        .kind  (last_q.kind),
        .value (rate)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q      <= '0;
            last_cyc_q <= '0;
            last_q     <= '{valid: 1'b0, kind: '0};
        end else begin
            cyc_q <= cyc_q + CYC_W'(1);
            if (issue_fire) begin
                last_cyc_q <= cyc_q;
                last_q     <= '{valid: 1'b1, kind: issue_kind};
            end
        end
    end

    assign elapsed    = cyc_q - last_cyc_q;
    assign spacing_ok = !last_q.valid ||
                        (elapsed >= {{(CYC_W-TIME_W){1'b0}}, rate});

endmodule

// File: rtl/mdu_lat_timer.sv
module mdu_lat_timer
    import mdu_issue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TIME_W-1:0] lat,
    output logic              fire
);
    logic [TIME_W-1:0] cnt_q;
    logic              run_q;

    // a latency of 0 behaves as 1
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                if (lat <= TIME_W'(1)) begin
                    fire  <= 1'b1;
                    run_q <= 1'b0;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= lat - TIME_W'(1);
                    run_q <= 1'b1;
                end
            end else if (run_q) begin
                cnt_q <= cnt_q - TIME_W'(1);
                if (cnt_q == TIME_W'(1)) begin
                    run_q <= 1'b0;
                    fire  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mdu_issue_ctrl.sv
module mdu_issue_ctrl
    import mdu_issue_pkg::*;
#(
    parameter int          TAG_W   = 4,
    parameter int          CYC_W   = 32,
    parameter logic [7:0]  LAT_MUL = 8'd3,
    parameter logic [7:0]  LAT_D8  = 8'd4,
    parameter logic [7:0]  LAT_D16 = 8'd6,
    parameter logic [7:0]  LAT_D24 = 8'd9,
    parameter logic [7:0]  LAT_D32 = 8'd12,
    parameter logic [7:0]  RPT_MUL = 8'd6,
    parameter logic [7:0]  RPT_D8  = 8'd7,
    parameter logic [7:0]  RPT_D16 = 8'd9,
    parameter logic [7:0]  RPT_D24 = 8'd12,
    parameter logic [7:0]  RPT_D32 = 8'd15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       req_cmd,
    input  logic             req_op,
    input  logic [31:0]      req_divisor,
    input  logic [TAG_W-1:0] req_tag,
    output logic             start_grant,
    output logic             end_complete,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag
);
    localparam logic [NUM_KINDS*TIME_W-1:0] LAT_TAB =
        {LAT_D32, LAT_D24, LAT_D16, LAT_D8, LAT_MUL};
    localparam logic [NUM_KINDS*TIME_W-1:0] RPT_TAB =
        {RPT_D32, RPT_D24, RPT_D16, RPT_D8, RPT_MUL};

    mdu_cmd_e          cmd;
    mdu_op_e           op;
    div_size_e         size;
    kind_t             kind;
    logic [TIME_W-1:0] lat;
    logic              spacing_ok;
    logic              timer_fire;

    logic              hold_q;
    logic [TAG_W-1:0]  hold_tag_q;
    logic              fin_q;

    logic              is_start;
    logic              is_end;
    logic              held_hit;
    logic              issue_fire;

    assign cmd = mdu_cmd_e'(req_cmd);
    assign op  = mdu_op_e'(req_op);

    mdu_size_class #(.DATA_W(32)) u_size (
        .divisor (req_divisor),
        .size    (size)
    );

    assign kind = kind_of(op, size);

    mdu_kind_table #(
        .NK  (NUM_KINDS),
        .TAB (LAT_TAB)
    ) u_lat (
        .kind  (kind),
        .value (lat)
    );

    mdu_spacing_gate #(
        .CYC_W   (CYC_W),
        .RPT_TAB (RPT_TAB)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .issue_fire (issue_fire),
        .issue_kind (kind),
        .spacing_ok (spacing_ok)
    );

    mdu_lat_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (issue_fire),
        .lat  (lat),
        .fire (timer_fire)
    );

    assign is_start   = (cmd == CMD_START);
    assign is_end     = (cmd == CMD_END);
    assign held_hit   = hold_q && (req_tag == hold_tag_q);
    assign issue_fire = is_start && !hold_q && spacing_ok;

    assign start_grant  = is_start && (held_hit || (!hold_q && spacing_ok));
    assign end_complete = is_end && held_hit && (fin_q || timer_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            hold_tag_q <= '0;
            fin_q      <= 1'b0;
        end else begin
            if (issue_fire) begin
                hold_q     <= 1'b1;
                hold_tag_q <= req_tag;
                fin_q      <= 1'b0;
            end else begin
                if (timer_fire)   fin_q  <= 1'b1;
                if (end_complete) hold_q <= 1'b0;
            end
        end
    end

    assign done_valid = timer_fire;
    assign done_tag   = hold_tag_q;

endmodule

// File: rtl/mdu_issue_ctrl_chk.sv
module mdu_issue_ctrl_chk #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       req_cmd,
    input logic [TAG_W-1:0] req_tag,
    input logic             start_grant,
    input logic             end_complete,
    input logic             done_valid,
    input logic [TAG_W-1:0] done_tag,
    input logic             issue_fire
);
    logic             c_held;
    logic [TAG_W-1:0] c_tag;
    logic             c_out;
    logic             c_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_held <= 1'b0;
            c_tag  <= '0;
            c_out  <= 1'b0;
            c_pend <= 1'b0;
        end else begin
            if (issue_fire) begin
                c_held <= 1'b1;
                c_tag  <= req_tag;
                c_out  <= 1'b1;
                c_pend <= 1'b0;
            end
            if (done_valid) begin
                c_out  <= 1'b0;
                c_pend <= 1'b1;
            end
            if (end_complete) begin
                c_held <= 1'b0;
                c_pend <= 1'b0;
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done_valid && !end_complete));

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    p_done_owner_r3: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (c_out && done_tag == c_tag));

    p_new_issue_gap_r4: assert property (@(posedge clk) disable iff (rst)
        issue_fire |=> !issue_fire);

    p_one_slot_r5: assert property (@(posedge clk) disable iff (rst)
        (req_cmd == 2'd1 && c_held && req_tag != c_tag) |-> !start_grant);

    p_rebind_r6: assert property (@(posedge clk) disable iff (rst)
        (req_cmd == 2'd1 && c_held && req_tag == c_tag)
            |-> (start_grant && !issue_fire));

    p_end_finished_r7: assert property (@(posedge clk) disable iff (rst)
        end_complete |-> (c_pend || done_valid));

    p_end_stranger_r8: assert property (@(posedge clk) disable iff (rst)
        (req_cmd == 2'd2 && !(c_held && req_tag == c_tag)) |-> !end_complete);

endmodule

bind mdu_issue_ctrl mdu_issue_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_cmd      (req_cmd),
    .req_tag      (req_tag),
    .start_grant  (start_grant),
    .end_complete (end_complete),
    .done_valid   (done_valid),
    .done_tag     (done_tag),
    .issue_fire   (issue_fire)
);

// File: tb/mdu_issue_ctrl_tb.sv
`timescale 1ns/1ps
module mdu_issue_ctrl_tb;

    localparam int L_MUL = 3,  L_D8 = 4, L_D16 = 6, L_D24 = 9,  L_D32 = 12;
    localparam int S_MUL = 6,  S_D8 = 7, S_D16 = 9, S_D24 = 12, S_D32 = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_cmd = 2'd0;
    logic        req_op = 1'b0;
    logic [31:0] req_divisor = '0;
    logic [3:0]  req_tag = '0;
    logic        start_grant;
    logic        end_complete;
    logic        done_valid;
    logic [3:0]  done_tag;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mdu_issue_ctrl #(
        .TAG_W(4), .CYC_W(32),
        .LAT_MUL(8'(L_MUL)), .LAT_D8(8'(L_D8)), .LAT_D16(8'(L_D16)),
        .LAT_D24(8'(L_D24)), .LAT_D32(8'(L_D32)),
        .RPT_MUL(8'(S_MUL)), .RPT_D8(8'(S_D8)), .RPT_D16(8'(S_D16)),
        .RPT_D24(8'(S_D24)), .RPT_D32(8'(S_D32))
    ) u_dut (
        .clk(clk), .rst(rst), .req_cmd(req_cmd), .req_op(req_op),
        .req_divisor(req_divisor), .req_tag(req_tag),
        .start_grant(start_grant), .end_complete(end_complete),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    function automatic int div_lat(logic [31:0] d);
        if (d <= 32'hFF)          return L_D8;
        else if (d <= 32'hFFFF)   return L_D16;
        else if (d <= 32'hFFFFFF) return L_D24;
        else                      return L_D32;
    endfunction

    function automatic int div_gap(logic [31:0] d);
        if (d <= 32'hFF)          return S_D8;
        else if (d <= 32'hFFFF)   return S_D16;
        else if (d <= 32'hFFFFFF) return S_D24;
        else                      return S_D32;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // one cycle of stimulus; outputs are sampled 1 ns after the falling edge
    task automatic drive(logic [1:0] c, logic op, logic [31:0] dv, logic [3:0] tg);
        @(negedge clk);
        req_cmd = c; req_op = op; req_divisor = dv; req_tag = tg;
        #1;
    endtask

    task automatic idle();
        drive(2'd0, 1'b0, 32'h0, 4'h0);
    endtask

    task automatic do_reset(int n);
        @(negedge clk);
        rst = 1'b1; req_cmd = 2'd0;
        repeat (n) @(negedge clk);
        rst = 1'b0;
    endtask

    // start, count down, and end-poll in the very cycle of the pulse
    task automatic run_op(logic op, logic [31:0] dv, logic [3:0] tg, int lat, string req);
        drive(2'd1, op, dv, tg);
        check(req, "start granted", start_grant, 1);
        for (int n = 1; n < lat; n++) begin
            idle();
            check(req, "done early", done_valid, 0);
        end
        drive(2'd2, 1'b0, 32'h0, tg);
        check(req, "done at latency", done_valid, 1);
        check(req, "done tag", done_tag, tg);
        check("R7", "end poll in pulse cycle", end_complete, 1);
    endtask

    task automatic deny_until(int from, int upto, string req);
        for (int n = from; n < upto; n++) begin
            drive(2'd1, 1'b0, 32'h0, 4'hE);
            check(req, "start inside spacing", start_grant, 0);
            check("R3", "pulse single", done_valid, 0);
        end
    endtask

    task automatic t_reset();
        idle();
        check("R1", "done after reset", done_valid, 0);
        drive(2'd2, 1'b0, 32'h0, 4'h0);
        check("R1", "end poll after reset", end_complete, 0);
        run_op(1'b0, 32'h0, 4'h1, L_MUL, "R1");
        deny_until(L_MUL + 1, S_MUL, "R4");
    endtask

    task automatic t_classes();
        logic [31:0] dvs [9] = '{32'h0, 32'hFF, 32'h100, 32'hFFFF, 32'h10000,
                                 32'hFFFFFF, 32'h1000000, 32'h8000_0000, 32'hFFFF_FFFF};
        for (int i = 0; i < 9; i++) begin
            run_op(1'b1, dvs[i], 4'(i + 2), div_lat(dvs[i]), "R2");
            deny_until(div_lat(dvs[i]) + 1, div_gap(dvs[i]), "R4");
        end
        run_op(1'b0, 32'hFFFF_FFFF, 4'hB, L_MUL, "R3");
        deny_until(L_MUL + 1, S_MUL, "R4");
    endtask

    task automatic t_busy();
        drive(2'd1, 1'b1, 32'h100, 4'h5);
        check("R5", "first start", start_grant, 1);
        drive(2'd1, 1'b0, 32'h0, 4'h6);
        check("R5", "other tag while running", start_grant, 0);
        drive(2'd1, 1'b1, 32'h100, 4'h5);
        check("R6", "held tag restart", start_grant, 1);
        drive(2'd2, 1'b0, 32'h0, 4'h5);
        check("R7", "end before expiry", end_complete, 0);
        drive(2'd2, 1'b0, 32'h0, 4'h6);
        check("R8", "end for stranger", end_complete, 0);
        idle();
        check("R6", "no early pulse", done_valid, 0);
        drive(2'd2, 1'b0, 32'h0, 4'h5);
        check("R6", "pulse at original time", done_valid, 1);
        check("R7", "end completes", end_complete, 1);
        idle();
        check("R3", "pulse single", done_valid, 0);
        deny_until(L_D16 + 2, S_D16, "R4");
    endtask

    task automatic t_late_end();
        drive(2'd1, 1'b1, 32'h42, 4'h3);
        check("R2", "d8 start", start_grant, 1);
        for (int n = 1; n < L_D8; n++) idle();
        idle();
        check("R3", "d8 pulse", done_valid, 1);
        idle();
        check("R3", "pulse single", done_valid, 0);
        drive(2'd1, 1'b1, 32'h42, 4'h3);
        check("R6", "held tag after expiry", start_grant, 1);
        drive(2'd1, 1'b0, 32'h0, 4'h4);
        check("R5", "other tag awaiting end", start_grant, 0);
        for (int n = 0; n < 5; n++) begin
            idle();
            check("R6", "no second pulse", done_valid, 0);
        end
        drive(2'd2, 1'b0, 32'h0, 4'h3);
        check("R7", "late end completes", end_complete, 1);
        drive(2'd2, 1'b0, 32'h0, 4'h3);
        check("R8", "end after release", end_complete, 0);
    endtask

    task automatic t_reset_mid();
        drive(2'd1, 1'b1, 32'h1234_5678, 4'h9);
        check("R2", "d32 start", start_grant, 1);
        repeat (3) idle();
        do_reset(2);
        run_op(1'b0, 32'h0, 4'hA, L_MUL, "R1");
        for (int n = 0; n < L_D32; n++) begin
            idle();
            check("R1", "cancelled pulse absent", done_valid, 0);
        end
        drive(2'd2, 1'b0, 32'h0, 4'h9);
        check("R8", "end for cancelled tag", end_complete, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_classes();
        t_busy();
        t_late_end();
        t_reset_mid();
        idle();
        report();
    end

endmodule